// File: doc/BRIEF.md
# Character-Unit LCD Timing Generator

This block produces the horizontal sync, vertical sync, data-enable, line-start strobe and frame-end interrupt for an RGB LCD panel. Horizontal timing is programmed in character units of eight pixel clocks. Vertical timing is programmed in lines. Software configures it through a simple register write port and observes it through a combinational read port. Memory fetch and pixel formatting sit outside this block.

Two refresh modes are available. In continuous mode frames follow one another without a gap. In one-shot mode the block arms itself and waits. Each trigger write then scans exactly one frame, sets the frame-end status bit and returns to waiting. Timing and polarity values written while a frame is being scanned are held in shadow registers. They are copied into the working set only when the next frame begins.

The scan controller has three states. ST_STOP: output is off. ST_ARMED: one-shot mode, waiting for a trigger. ST_SCAN: a frame is being scanned. The transitions are:
- START_CONT: ST_STOP to ST_SCAN, when run is set in continuous mode.
- START_ONE: ST_STOP to ST_ARMED, when run is set in one-shot mode.
- FIRE: ST_ARMED to ST_SCAN, on a trigger, or when one-shot mode is cleared.
- DISARM: ST_ARMED to ST_STOP, when run is cleared.
- REPEAT: ST_SCAN to ST_SCAN, at the end of a frame in continuous mode.
- REARM: ST_SCAN to ST_ARMED, at the end of a frame in one-shot mode.
- HALT: ST_SCAN to ST_STOP, at the end of a frame when run has been cleared.

Register map. A register is selected by its word index, and all fields are read back as written.

| Index | Register | Fields |
|---|---|---|
| 0 | control | bit 0: run |
| 1 | mode | bit 0: one-shot; bits 24 to 28: polarity controls (see R5) |
| 2 | trigger | write-only; bit 0 = 1 fires a one-shot frame |
| 3 | horizontal total | [15:0] total units; [31:16] active units |
| 4 | horizontal sync | [15:0] sync start unit; [31:16] sync width in units |
| 5 | vertical total | [15:0] total lines; [31:16] active lines |
| 6 | vertical sync | [15:0] sync start line; [31:16] sync width in lines |
| 7 | interrupt enable | bit 10: frame-end enable |
| 8 | status | bit 10: frame-end flag |
| 9 | power | read-only; [1:0]: power status |

Top module: `lcd_scan_gen`

## Requirements
- R1: After reset the block is stopped. The power field (index 9, bits 1:0) reads 0, and the status flag and irq are 0. All panel outputs are at their inactive level, which is low while the polarity bits are 0.
- R2: A line lasts total-units × 8 clocks (index 3, bits 15:0). The raw data-enable is high while the character unit is below the active units (index 3, bits 31:16) and the line is below the active lines (index 5, bits 31:16).
- R3: The raw horizontal sync is high for units from the start unit (index 4, bits 15:0) up to, but not including, start plus width (index 4, bits 31:16).
- R4: The raw vertical sync is high for lines from the start line (index 6, bits 15:0) up to, but not including, start plus width (index 6, bits 31:16). A frame lasts total lines (index 5, bits 15:0).
- R5: Each mode bit that is set changes one output:
  - bit 28 makes vertical sync active low;
  - bit 27 makes horizontal sync active low;
  - bit 26 inverts the strobe;
  - bit 25 inverts data-enable;
  - bit 24 drives the dot-clock inversion output high.
- R6: The raw strobe is high for one clock, on the first pixel clock of every active line.
- R7: In continuous mode (mode bit 0 = 0), with run set, frames repeat back to back with no idle clock between them.
- R8: In one-shot mode (mode bit 0 = 1), writing 1 to bit 0 of the trigger register while armed scans exactly one frame, and the block then returns to armed. A trigger written during a scan has no effect.
- R9: The status flag (index 8, bit 10) sets on the clock after the last clock of the final line. Writing 0 to bit 10 clears it. Writing 1 leaves it unchanged. When a set and a clear fall on the same clock, the set wins.
- R10: irq is high exactly when both the status flag and the enable bit (index 7, bit 10) are 1.
- R11: The power field reads 3 in ST_ARMED and ST_SCAN, and 0 in ST_STOP. If run is cleared during a scan, the frame is completed before the block stops.
- R12: Timing values written during a scan take effect only at the start of the next frame. Polarity values take effect at the next frame start, or at once while the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | AW | register word index for writes |
| wr_data | input | 32 | write data |
| rd_addr | input | AW | register word index for reads |
| rd_data | output | 32 | read data, combinational |
| lcd_hsync | output | 1 | horizontal sync after polarity |
| lcd_vsync | output | 1 | vertical sync after polarity |
| lcd_de | output | 1 | data-enable after polarity |
| lcd_dstb | output | 1 | line-start strobe after polarity |
| lcd_dclk_inv | output | 1 | dot-clock inversion select |
| irq | output | 1 | frame-end interrupt |

## Verification
The assertions check relations that must hold on every cycle:
- the status flag follows the final clock of a frame;
- irq never rises without the status flag;
- HALT and REARM follow a frame end;
- an armed block holds without a trigger;
- raw data-enable and syncs are high only in ST_SCAN;
- the working timing set stays stable inside a frame.

Only the bench's scenarios can show the exact window positions, the polarity changes and the deferred effect of a mid-frame timing write. They also show that a trigger written during a scan is ignored, and that clearing run lets the frame finish.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int DW = 32;
    localparam int FW = 16;
    localparam int NREG = 10;
    localparam int NTIM = 4;

    localparam int A_CTRL = 0;
    localparam int A_MODE = 1;
    localparam int A_TRIG = 2;
    localparam int A_HTIM = 3;
    localparam int A_HSYN = 4;
    localparam int A_VTIM = 5;
    localparam int A_VSYN = 6;
    localparam int A_IEN  = 7;
    localparam int A_STAT = 8;
    localparam int A_PWR  = 9;

    localparam int B_VS_LOW  = 28;
    localparam int B_HS_LOW  = 27;
    localparam int B_STB_INV = 26;
    localparam int B_DE_INV  = 25;
    localparam int B_DCK_INV = 24;
    localparam int B_FE      = 10;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SCAN  = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic [FW-1:0] ht;
        logic [FW-1:0] ha;
        logic [FW-1:0] hs;
        logic [FW-1:0] hw;
        logic [FW-1:0] vt;
        logic [FW-1:0] va;
        logic [FW-1:0] vs;
        logic [FW-1:0] vw;
    } timing_t;

    typedef struct packed {
        logic vs_low;
        logic hs_low;
        logic stb_inv;
        logic de_inv;
        logic dck_inv;
    } pol_t;

endpackage

// File: rtl/lcd_scan_regs.sv
module lcd_scan_regs
    import lcd_scan_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          fe_set,
    input  logic [1:0]    pwr,
    output logic [DW-1:0] rd_data,
    output timing_t       shadow_t,
    output pol_t          shadow_p,
    output logic          run,
    output logic          oneshot,
    output logic          trig,
    output logic          ien,
    output logic          fe_flag
);

    logic [NREG-1:0] wsel;
    logic [DW-1:0]   tim_q [NTIM];
    logic            run_q;
    logic            one_q;
    logic            ien_q;
    logic            fe_q;
    pol_t            pol_q;

    // one write select per register index
    for (genvar i = 0; i < NREG; i++) begin : g_wsel
        assign wsel[i] = wr_en && (wr_addr == AW'(i));
    end

    // the four timing registers share one structure
    for (genvar g = 0; g < NTIM; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tim_q[g] <= '0;
            end else if (wsel[A_HTIM+g]) begin
                tim_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            one_q <= 1'b0;
            ien_q <= 1'b0;
            pol_q <= '0;
        end else begin
            if (wsel[A_CTRL]) begin
                run_q <= wr_data[0];
            end
            if (wsel[A_MODE]) begin
                one_q         <= wr_data[0];
                pol_q.vs_low  <= wr_data[B_VS_LOW];
                pol_q.hs_low  <= wr_data[B_HS_LOW];
                pol_q.stb_inv <= wr_data[B_STB_INV];
                pol_q.de_inv  <= wr_data[B_DE_INV];
                pol_q.dck_inv <= wr_data[B_DCK_INV];
            end
            if (wsel[A_IEN]) begin
                ien_q <= wr_data[B_FE];
            end
        end
    end

    // status flag: a set beats a write-zero clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_q <= 1'b0;
        end else if (fe_set) begin
            fe_q <= 1'b1;
        end else if (wsel[A_STAT] && !wr_data[B_FE]) begin
            fe_q <= 1'b0;
        end
    end

    assign trig    = wsel[A_TRIG] && wr_data[0];
    assign run     = run_q;
    assign oneshot = one_q;
    assign ien     = ien_q;
    assign fe_flag = fe_q;
    assign shadow_p = pol_q;

    always_comb begin
        shadow_t.ht = tim_q[0][FW-1:0];
        shadow_t.ha = tim_q[0][DW-1:FW];
        shadow_t.hs = tim_q[1][FW-1:0];
        shadow_t.hw = tim_q[1][DW-1:FW];
        shadow_t.vt = tim_q[2][FW-1:0];
        shadow_t.va = tim_q[2][DW-1:FW];
        shadow_t.vs = tim_q[3][FW-1:0];
        shadow_t.vw = tim_q[3][DW-1:FW];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(A_CTRL): rd_data[0] = run_q;
            AW'(A_MODE): begin
                rd_data[0]         = one_q;
                rd_data[B_VS_LOW]  = pol_q.vs_low;
                rd_data[B_HS_LOW]  = pol_q.hs_low;
                rd_data[B_STB_INV] = pol_q.stb_inv;
                rd_data[B_DE_INV]  = pol_q.de_inv;
                rd_data[B_DCK_INV] = pol_q.dck_inv;
            end
            AW'(A_HTIM): rd_data = tim_q[0];
            AW'(A_HSYN): rd_data = tim_q[1];
            AW'(A_VTIM): rd_data = tim_q[2];
            AW'(A_VSYN): rd_data = tim_q[3];
            AW'(A_IEN):  rd_data[B_FE] = ien_q;
            AW'(A_STAT): rd_data[B_FE] = fe_q;
            AW'(A_PWR):  rd_data[1:0] = pwr;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_scan_pkg::*;
#(
    parameter int UNIT_CLKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        oneshot,
    input  logic        trig,
    input  timing_t     shadow_t,
    input  pol_t        shadow_p,
    output scan_state_e state,
    output logic [$clog2(UNIT_CLKS)-1:0] pix,
    output logic [FW-1:0] hu,
    output logic [FW-1:0] ln,
    output timing_t     act_t,
    output pol_t        act_p,
    output logic        frame_last,
    output logic [1:0]  pwr
);

    localparam int PW = $clog2(UNIT_CLKS);
    localparam logic [PW-1:0] PIX_LAST = PW'(UNIT_CLKS - 1);

    scan_state_e state_q, state_d;
    logic [PW-1:0] pix_q;
    logic [FW-1:0] hu_q, ln_q;
    timing_t act_q;
    pol_t    pol_q;
    logic    unit_last, line_last, last, load;

    assign unit_last = (pix_q == PIX_LAST);
    assign line_last = unit_last && (hu_q == act_q.ht - FW'(1));
    assign last      = (state_q == ST_SCAN) && line_last && (ln_q == act_q.vt - FW'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (run) begin
                    state_d = oneshot ? ST_ARMED : ST_SCAN;      // START_ONE / START_CONT
                end
            end
            ST_ARMED: begin
                if (!run) begin
                    state_d = ST_STOP;                           // DISARM
                end else if (trig || !oneshot) begin
                    state_d = ST_SCAN;                           // FIRE
                end
            end
            ST_SCAN: begin
                if (last) begin
                    if (!run) begin
                        state_d = ST_STOP;                       // HALT
                    end else if (oneshot) begin
                        state_d = ST_ARMED;                      // REARM
                    end else begin
                        state_d = ST_SCAN;                       // REPEAT
                    end
                end
            end
            default: state_d = ST_STOP;
        endcase
    end

    assign load = (state_d == ST_SCAN) && ((state_q != ST_SCAN) || last);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // character and line counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
            hu_q  <= '0;
            ln_q  <= '0;
        end else if (load) begin
            pix_q <= '0;
            hu_q  <= '0;
            ln_q  <= '0;
        end else if ((state_q == ST_SCAN) && !last) begin
            if (unit_last) begin
                pix_q <= '0;
                if (line_last) begin
                    hu_q <= '0;
                    ln_q <= ln_q + FW'(1);
                end else begin
                    hu_q <= hu_q + FW'(1);
                end
            end else begin
                pix_q <= pix_q + PW'(1);
            end
        end
    end

    // working copies, refreshed only at a frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            pol_q <= '0;
        end else begin
            if (load) begin
                act_q <= shadow_t;
            end
            if (load || (state_q == ST_STOP)) begin
                pol_q <= shadow_p;
            end
        end
    end

    // outputs
    always_comb begin
        state      = state_q;
        pix        = pix_q;
        hu         = hu_q;
        ln         = ln_q;
        act_t      = act_q;
        act_p      = pol_q;
        frame_last = last;
        pwr        = (state_q == ST_STOP) ? 2'b00 : 2'b11;
    end

endmodule

// File: rtl/lcd_scan_out.sv
module lcd_scan_out
    import lcd_scan_pkg::*;
#(
    parameter int PW = 3
) (
    input  scan_state_e   state,
    input  logic [PW-1:0] pix,
    input  logic [FW-1:0] hu,
    input  logic [FW-1:0] ln,
    input  timing_t       act_t,
    input  pol_t          act_p,
    output logic          de_raw,
    output logic          hs_raw,
    output logic          vs_raw,
    output logic          stb_raw,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic          lcd_dstb,
    output logic          lcd_dclk_inv
);

    logic          scanning;
    logic [FW:0]   hs_end, vs_end;

    assign scanning = (state == ST_SCAN);
    assign hs_end   = {1'b0, act_t.hs} + {1'b0, act_t.hw};
    assign vs_end   = {1'b0, act_t.vs} + {1'b0, act_t.vw};

    always_comb begin
        de_raw  = scanning && (hu < act_t.ha) && (ln < act_t.va);
        hs_raw  = scanning && (hu >= act_t.hs) && ({1'b0, hu} < hs_end);
        vs_raw  = scanning && (ln >= act_t.vs) && ({1'b0, ln} < vs_end);
        stb_raw = de_raw && (hu == '0) && (pix == '0);
    end

    assign lcd_hsync    = hs_raw ^ act_p.hs_low;
    assign lcd_vsync    = vs_raw ^ act_p.vs_low;
    assign lcd_de       = de_raw ^ act_p.de_inv;
    assign lcd_dstb     = stb_raw ^ act_p.stb_inv;
    assign lcd_dclk_inv = act_p.dck_inv;

endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen
    import lcd_scan_pkg::*;
#(
    parameter int AW        = 4,
    parameter int UNIT_CLKS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic          lcd_dstb,
    output logic          lcd_dclk_inv,
    output logic          irq
);

    localparam int PW = $clog2(UNIT_CLKS);

    timing_t       shadow_t, act_t;
    pol_t          shadow_p, act_p;
    logic          run, oneshot, trig, ien, fe_flag, frame_last;
    logic [1:0]    pwr;
    scan_state_e   state;
    logic [PW-1:0] pix;
    logic [FW-1:0] hu, ln;
    logic          de_raw, hs_raw, vs_raw, stb_raw;

    lcd_scan_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .fe_set   (frame_last),
        .pwr      (pwr),
        .rd_data  (rd_data),
        .shadow_t (shadow_t),
        .shadow_p (shadow_p),
        .run      (run),
        .oneshot  (oneshot),
        .trig     (trig),
        .ien      (ien),
        .fe_flag  (fe_flag)
    );

    lcd_scan_fsm #(.UNIT_CLKS(UNIT_CLKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .oneshot    (oneshot),
        .trig       (trig),
        .shadow_t   (shadow_t),
        .shadow_p   (shadow_p),
        .state      (state),
        .pix        (pix),
        .hu         (hu),
        .ln         (ln),
        .act_t      (act_t),
        .act_p      (act_p),
        .frame_last (frame_last),
        .pwr        (pwr)
    );

    lcd_scan_out #(.PW(PW)) u_out (
        .state        (state),
        .pix          (pix),
        .hu           (hu),
        .ln           (ln),
        .act_t        (act_t),
        .act_p        (act_p),
        .de_raw       (de_raw),
        .hs_raw       (hs_raw),
        .vs_raw       (vs_raw),
        .stb_raw      (stb_raw),
        .lcd_hsync    (lcd_hsync),
        .lcd_vsync    (lcd_vsync),
        .lcd_de       (lcd_de),
        .lcd_dstb     (lcd_dstb),
        .lcd_dclk_inv (lcd_dclk_inv)
    );

    assign irq = fe_flag && ien;

endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
    import lcd_scan_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input scan_state_e state,
    input logic        frame_last,
    input logic        fe_flag,
    input logic        run,
    input logic        oneshot,
    input logic        trig,
    input logic        irq,
    input logic        de_raw,
    input logic        hs_raw,
    input logic        vs_raw,
    input timing_t     act_t
);

    // R9
    fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> fe_flag);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fe_flag);

    // R11
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && !run) |=> (state == ST_STOP));

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last && run && oneshot) |=> (state == ST_ARMED));

    // R8
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && run && oneshot && !trig) |=> (state == ST_ARMED));

    // R2
    de_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (state == ST_SCAN));

    // R3
    hs_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_raw |-> (state == ST_SCAN));

    // R4
    vs_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_raw |-> (state == ST_SCAN));

    // R12
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && $past(state) == ST_SCAN && !$past(frame_last)) |-> $stable(act_t));

endmodule

bind lcd_scan_gen lcd_scan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .frame_last (frame_last),
    .fe_flag    (fe_flag),
    .run        (run),
    .oneshot    (oneshot),
    .trig       (trig),
    .irq        (irq),
    .de_raw     (de_raw),
    .hs_raw     (hs_raw),
    .vs_raw     (vs_raw),
    .act_t      (act_t)
);

// File: tb/sim_lcd_scan_gen.sv
module sim_lcd_scan_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = 4'd9;
    logic [31:0] rd_data;
    logic        lcd_hsync, lcd_vsync, lcd_de, lcd_dstb, lcd_dclk_inv, irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_scan_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_de(lcd_de), .lcd_dstb(lcd_dstb), .lcd_dclk_inv(lcd_dclk_inv), .irq(irq)
    );

    // behavioural reference: pixel position x within the line, line y
    int m_state;  // 0 stopped, 1 armed, 2 scanning
    int x, y;
    int m_run, m_one, m_ien, m_stat;
    logic [31:0] m_mode;
    logic [31:0] m_tim [4];
    int a_ht, a_ha, a_hs, a_hw, a_vt, a_va, a_vs, a_vw;
    logic [4:0] a_pol;  // {vs_low, hs_low, stb_inv, de_inv, dck_inv}
    int fe_count;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; x = 0; y = 0;
            m_run = 0; m_one = 0; m_ien = 0; m_stat = 0;
            m_mode = '0;
            for (int i = 0; i < 4; i++) m_tim[i] = '0;
            a_ht = 0; a_ha = 0; a_hs = 0; a_hw = 0;
            a_vt = 0; a_va = 0; a_vs = 0; a_vw = 0;
            a_pol = '0;
            fe_count = 0;
        end else begin
            bit trg, lst, ld;
            int nst;
            trg = wr_en && wr_addr == 4'd2 && wr_data[0];
            lst = (m_state == 2) && (x == a_ht * 8 - 1) && (y == a_vt - 1);
            nst = m_state;
            if (m_state == 0 && m_run != 0) nst = (m_one != 0) ? 1 : 2;
            else if (m_state == 1) begin
                if (m_run == 0) nst = 0;
                else if (trg || m_one == 0) nst = 2;
            end else if (m_state == 2 && lst) begin
                if (m_run == 0) nst = 0;
                else if (m_one != 0) nst = 1;
                else nst = 2;
            end
            ld = (nst == 2) && (m_state != 2 || lst);
            if (ld || m_state == 0) a_pol = m_mode[28:24];
            if (ld) begin
                a_ht = m_tim[0][15:0]; a_ha = m_tim[0][31:16];
                a_hs = m_tim[1][15:0]; a_hw = m_tim[1][31:16];
                a_vt = m_tim[2][15:0]; a_va = m_tim[2][31:16];
                a_vs = m_tim[3][15:0]; a_vw = m_tim[3][31:16];
                x = 0; y = 0;
            end else if (m_state == 2) begin
                x++;
                if (x == a_ht * 8) begin x = 0; y++; end
            end
            if (lst) begin m_stat = 1; fe_count++; end
            else if (wr_en && wr_addr == 4'd8 && !wr_data[10]) m_stat = 0;
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_run = wr_data[0];
                    4'd1: m_mode = wr_data & 32'h1F00_0001;
                    4'd3: m_tim[0] = wr_data;
                    4'd4: m_tim[1] = wr_data;
                    4'd5: m_tim[2] = wr_data;
                    4'd6: m_tim[3] = wr_data;
                    4'd7: m_ien = wr_data[10];
                    default: ;
                endcase
            end
            m_one = m_mode[0];
            m_state = nst;
        end
    end

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        case (a)
            4'd0: return {31'd0, m_run[0]};
            4'd1: return m_mode;
            4'd3: return m_tim[0];
            4'd4: return m_tim[1];
            4'd5: return m_tim[2];
            4'd6: return m_tim[3];
            4'd7: return {21'd0, m_ien[0], 10'd0};
            4'd8: return {21'd0, m_stat[0], 10'd0};
            4'd9: return (m_state == 0) ? 32'd0 : 32'd3;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every clock, away from both edges
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done) begin
            bit sc, e_de, e_hs, e_vs, e_stb;
            int u;
            sc = (m_state == 2);
            u = x / 8;
            e_de  = sc && u < a_ha && y < a_va;
            e_hs  = sc && u >= a_hs && u < a_hs + a_hw;
            e_vs  = sc && y >= a_vs && y < a_vs + a_vw;
            e_stb = e_de && x == 0;
            // R2 R7 data-enable in continuous and single frames
            chk(lcd_de == (e_de ^ a_pol[1]), "R2 R7 de", lcd_de, e_de ^ a_pol[1]);
            // R3
            chk(lcd_hsync == (e_hs ^ a_pol[3]), "R3 hsync", lcd_hsync, e_hs ^ a_pol[3]);
            // R4
            chk(lcd_vsync == (e_vs ^ a_pol[4]), "R4 vsync", lcd_vsync, e_vs ^ a_pol[4]);
            // R6
            chk(lcd_dstb == (e_stb ^ a_pol[2]), "R6 strobe", lcd_dstb, e_stb ^ a_pol[2]);
            // R5
            chk(lcd_dclk_inv == a_pol[0], "R5 dclk_inv", lcd_dclk_inv, a_pol[0]);
            // R10
            chk(irq == (m_stat != 0 && m_ien != 0), "R10 irq", irq, (m_stat != 0 && m_ien != 0));
            // R9 R11 R12 register readback
            chk(rd_data == model_rd(rd_addr), "R9 R11 R12 rd_data", rd_data, model_rd(rd_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int fe0;
        idle(5);
        rst_n = 1'b1;
        @(posedge clk); #5;
        // R1 reset state
        chk(rd_data == 32'd0, "R1 power", rd_data, 0);
        chk(lcd_de == 1'b0 && lcd_hsync == 1'b0 && lcd_vsync == 1'b0, "R1 outputs",
            {lcd_de, lcd_hsync, lcd_vsync}, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        wr(4'd3, {16'd4, 16'd6});
        wr(4'd4, {16'd1, 16'd4});
        wr(4'd5, {16'd3, 16'd5});
        wr(4'd6, {16'd1, 16'd3});
        wr(4'd7, 32'h0000_0400);
        wr(4'd0, 32'd1);             // continuous start, R7
        idle(300);
        wr(4'd3, {16'd3, 16'd5});    // R12 mid-frame change
        idle(500);
        wr(4'd1, 32'h1F00_0000);     // R5 all polarities
        idle(500);
        rd_addr = 4'd8;
        wr(4'd8, 32'h0000_0400);     // R9 write 1 leaves flag
        idle(3);
        wr(4'd8, 32'h0000_0000);     // R9 write 0 clears
        idle(5);
        rd_addr = 4'd9;
        wr(4'd0, 32'd0);             // R11 stop after frame
        idle(250);
        @(posedge clk); #5;
        chk(rd_data == 32'd0, "R11 stopped", rd_data, 0);

        wr(4'd1, 32'h1F00_0001);     // R8 one-shot
        wr(4'd0, 32'd1);
        idle(100);
        fe0 = fe_count;
        wr(4'd2, 32'd1);             // fire
        idle(40);
        wr(4'd2, 32'd1);             // ignored during scan, R8
        idle(300);
        @(posedge clk); #5;
        chk(fe_count == fe0 + 1, "R8 single frame", fe_count - fe0, 1);
        chk(rd_data == 32'd3, "R11 armed power", rd_data, 3);
        rd_addr = 4'd8;
        wr(4'd2, 32'd1);
        idle(250);
        @(posedge clk); #5;
        chk(fe_count == fe0 + 2, "R8 second frame", fe_count - fe0, 2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule